// File: doc/BRIEF.md
# Tester Pin Channel Formatter and Comparator

This block sits between the pattern store of a digital tester and its pin electronics. It serves several channels. For each pattern step the sequencer presents a drive code and an expected-response code for every channel and pulses a step-start input. The block latches these codes.

When the phase strobe is sampled high, the block converts the latched drive code into a drive-data bit and a drive-enable bit for the pin driver. While the compare window input is high, it samples the receiver's high and low comparator outputs on every clock. It judges each sample against the expected code and accumulates failures over the whole window.

When the window closes, the block publishes one result per channel. That result is either the pass/fail outcome or the last raw comparator pair. At the same time it registers a single combined error flag, which the sequencer uses for branching, halting or error counting. An over-current input per channel can latch a lockout that keeps that channel's driver disabled and removes it from error reporting. The lockout stays until an explicit clear.

Top module: `pinfc_top`

## Requirements
- R1: After reset, pin_data, pin_en, rec_result, rec_valid and err_any are all zero and no channel is locked out.
- R2: Channel i takes its drive code from drv_code[2i+1:2i] and its expected code from exp_code[2i+1:2i]. Both are latched on a clock where step_start is high. The drive outputs change only on a clock where phase_strobe is sampled high, and the new value is visible right after that edge. Drive code 00 gives data 0 with enable 1, and drive code 01 gives data 1 with enable 1.
- R3: Drive code 10 sets the enable to 0 and keeps the data bit. Drive code 11 keeps both the data bit and the enable bit unchanged.
- R4: The comparator inputs resp_hi and resp_lo affect the result only on clocks where win is high. Values present while win is low are ignored.
- R5: An expected code passes only for these comparator pairs: 00 needs resp_lo=1 and resp_hi=0; 01 needs resp_hi=1 and resp_lo=0; 10 needs both inputs at 0. Expected code 11 never fails.
- R6: A window closes on the first clock where win is low after a clock where it was high. A channel fails if any sample in the window failed. Results are published at the closing edge, and rec_valid is a one-clock pulse right after that edge.
- R7: With raw_mode low at the closing clock, rec_result[2i] is channel i's fail bit and rec_result[2i+1] is 0. With raw_mode high, rec_result[2i+1] is resp_hi and rec_result[2i] is resp_lo, both taken from the last window cycle.
- R8: err_any is the OR of all channel fail bits, registered at the window close. It returns to 0 right after a clock where step_start is high.
- R9: When oc_en is high at a clock, a high oc_in bit locks out its channel. From the next cycle that channel's pin_en is 0. When oc_en is low, oc_in is ignored.
- R10: A lockout persists after oc_in falls and is released only by a clock where oc_clr is high. A clear in the same clock as a new over-current wins, so the channel is not locked.
- R11: A locked-out channel has fail bit 0 in compare mode and never contributes to err_any. Its pin_en returns to the latched enable once the lockout is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_start | input | 1 | Start of pattern step; latches codes and clears step state |
| drv_code | input | 2*NCH | Drive code, 2 bits per channel |
| exp_code | input | 2*NCH | Expected-response code, 2 bits per channel |
| phase_strobe | input | 1 | Drive timing edge qualifier |
| win | input | 1 | Compare window |
| resp_hi | input | NCH | Receiver high comparator outputs |
| resp_lo | input | NCH | Receiver low comparator outputs |
| raw_mode | input | 1 | Select raw response (1) or pass/fail result (0) |
| oc_in | input | NCH | Over-current indications |
| oc_en | input | 1 | Enable over-current lockout |
| oc_clr | input | 1 | Clear all lockouts |
| pin_data | output | NCH | Drive data to the pin drivers |
| pin_en | output | NCH | Drive enable to the pin drivers |
| rec_result | output | 2*NCH | Per-channel result for result storage |
| rec_valid | output | 1 | One-cycle pulse when rec_result is new |
| err_any | output | 1 | Combined step error to the sequencer |

## Verification
Drive outputs are due one edge after a sampled phase strobe. Lockout takes effect one edge after the sampled over-current. Results, rec_valid and err_any are due one edge after the window-closing clock. The clear of err_any is due one edge after step_start.

The bench changes inputs on the falling clock edge and reads outputs on the next falling edge, after exactly one rising edge has passed. Each check therefore lands in the cycle where its result is due. The bench also checks rec_valid one cycle later to confirm the pulse has ended.

// File: rtl/pinfc_pkg.sv
package pinfc_pkg;

  typedef enum logic [1:0] {
    DRV_LO   = 2'b00,
    DRV_HI   = 2'b01,
    DRV_OFF  = 2'b10,
    DRV_KEEP = 2'b11
  } drv_code_e;

  typedef enum logic [1:0] {
    EXP_LO  = 2'b00,
    EXP_HI  = 2'b01,
    EXP_MID = 2'b10,
    EXP_ANY = 2'b11
  } exp_code_e;

  typedef struct packed {
    logic data;
    logic en;
  } drv_state_t;

  // Next driver state for one channel given its code and current state.
  function automatic drv_state_t next_drive(input logic [1:0] code, input drv_state_t cur);
    drv_state_t n;
    n = cur;
    case (drv_code_e'(code))
      DRV_LO:   begin n.data = 1'b0; n.en = 1'b1; end
      DRV_HI:   begin n.data = 1'b1; n.en = 1'b1; end
      DRV_OFF:  n.en = 1'b0;
      default:  n = cur;
    endcase
    return n;
  endfunction

  // One-sample judgement: 1 means the comparator pair disagrees with the code.
  function automatic logic judge_fail(input logic [1:0] code, input logic hi, input logic lo);
    logic [1:0] seen;
    seen = {hi, lo};
    case (exp_code_e'(code))
      EXP_LO:  return seen != 2'b01;
      EXP_HI:  return seen != 2'b10;
      EXP_MID: return seen != 2'b00;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pinfc_drive.sv
module pinfc_drive #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [2*NCH-1:0] codes,
  output logic [NCH-1:0]   data,
  output logic [NCH-1:0]   en
);
  import pinfc_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    drv_state_t st;
    always_ff @(posedge clk) begin
      if (!rst_n)      st <= '0;
      else if (strobe) st <= next_drive(codes[2*g +: 2], st);
    end
    assign data[g] = st.data;
    assign en[g]   = st.en;
  end
endmodule

// File: rtl/pinfc_lock.sv
module pinfc_lock #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_in,
  input  logic           oc_en,
  input  logic           oc_clr,
  output logic [NCH-1:0] lock
);
  always_ff @(posedge clk) begin
    if (!rst_n)      lock <= '0;
    else if (oc_clr) lock <= '0;
    else if (oc_en)  lock <= lock | oc_in;
  end
endmodule

// File: rtl/pinfc_judge.sv
module pinfc_judge #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_start,
  input  logic             win,
  input  logic             raw_mode,
  input  logic [2*NCH-1:0] exp_codes,
  input  logic [NCH-1:0]   resp_hi,
  input  logic [NCH-1:0]   resp_lo,
  input  logic [NCH-1:0]   lock,
  output logic [2*NCH-1:0] rec_result,
  output logic             rec_valid,
  output logic             err_any,
  output logic             win_close
);
  import pinfc_pkg::*;

  logic           win_d;
  logic [NCH-1:0] sample_fail;
  logic [NCH-1:0] acc_fail;
  logic [NCH-1:0] last_hi;
  logic [NCH-1:0] last_lo;
  logic [NCH-1:0] gated_fail;

  function automatic logic [2*NCH-1:0] pack_result(input logic raw,
                                                   input logic [NCH-1:0] fail,
                                                   input logic [NCH-1:0] hi,
                                                   input logic [NCH-1:0] lo);
    logic [2*NCH-1:0] r;
    for (int i = 0; i < NCH; i++) begin
      r[2*i+1] = raw ? hi[i] : 1'b0;
      r[2*i]   = raw ? lo[i] : fail[i];
    end
    return r;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sample_fail[g] = judge_fail(exp_codes[2*g +: 2], resp_hi[g], resp_lo[g]);
  end

  assign win_close  = win_d & ~win;
  assign gated_fail = acc_fail & ~lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_d    <= 1'b0;
      acc_fail <= '0;
      last_hi  <= '0;
      last_lo  <= '0;
    end else begin
      win_d <= win;
      if (step_start)  acc_fail <= '0;
      else if (win)    acc_fail <= acc_fail | sample_fail;
      if (win) begin
        last_hi <= resp_hi;
        last_lo <= resp_lo;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_result <= '0;
      rec_valid  <= 1'b0;
      err_any    <= 1'b0;
    end else begin
      rec_valid <= win_close;
      if (win_close) rec_result <= pack_result(raw_mode, gated_fail, last_hi, last_lo);
      if (step_start)     err_any <= 1'b0;
      else if (win_close) err_any <= |gated_fail;
    end
  end
endmodule

// File: rtl/pinfc_top.sv
module pinfc_top #(
  parameter int NCH = 4,
  localparam int CW = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_start,
  input  logic [CW-1:0] drv_code,
  input  logic [CW-1:0] exp_code,
  input  logic          phase_strobe,
  input  logic          win,
  input  logic [NCH-1:0] resp_hi,
  input  logic [NCH-1:0] resp_lo,
  input  logic          raw_mode,
  input  logic [NCH-1:0] oc_in,
  input  logic          oc_en,
  input  logic          oc_clr,
  output logic [NCH-1:0] pin_data,
  output logic [NCH-1:0] pin_en,
  output logic [CW-1:0] rec_result,
  output logic          rec_valid,
  output logic          err_any
);
  logic [CW-1:0]  drv_q;
  logic [CW-1:0]  exp_q;
  logic [NCH-1:0] en_raw;
  logic [NCH-1:0] oc_lock;
  logic           win_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q <= '0;
      exp_q <= '0;
    end else if (step_start) begin
      drv_q <= drv_code;
      exp_q <= exp_code;
    end
  end

  pinfc_drive #(.NCH(NCH)) u_drive (
    .clk(clk), .rst_n(rst_n), .strobe(phase_strobe), .codes(drv_q),
    .data(pin_data), .en(en_raw)
  );

  pinfc_lock #(.NCH(NCH)) u_lock (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_in), .oc_en(oc_en), .oc_clr(oc_clr),
    .lock(oc_lock)
  );

  pinfc_judge #(.NCH(NCH)) u_judge (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .win(win),
    .raw_mode(raw_mode), .exp_codes(exp_q), .resp_hi(resp_hi), .resp_lo(resp_lo),
    .lock(oc_lock), .rec_result(rec_result), .rec_valid(rec_valid),
    .err_any(err_any), .win_close(win_close)
  );

  assign pin_en = en_raw & ~oc_lock;
endmodule

// File: rtl/pinfc_chk.sv
module pinfc_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           phase_strobe,
  input logic           step_start,
  input logic           win,
  input logic           oc_clr,
  input logic [NCH-1:0] pin_data,
  input logic [NCH-1:0] pin_en,
  input logic [NCH-1:0] oc_lock,
  input logic           rec_valid,
  input logic           err_any,
  input logic           win_close
);
  assert_drive_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_strobe |=> $stable(pin_data));

  assert_lock_blocks_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lock & pin_en) == '0);

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_clr |=> (($past(oc_lock) & ~oc_lock) == '0));

  assert_valid_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !$past(win));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> rec_valid);

  assert_err_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |=> !err_any);

  assert_err_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> rec_valid);
endmodule

bind pinfc_top pinfc_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_strobe(phase_strobe), .step_start(step_start),
  .win(win), .oc_clr(oc_clr), .pin_data(pin_data), .pin_en(pin_en),
  .oc_lock(oc_lock), .rec_valid(rec_valid), .err_any(err_any), .win_close(win_close)
);

// File: tb/sim_pinfc_top.sv
module sim_pinfc_top;
  localparam int NCH = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic step_start = 0, phase_strobe = 0, win = 0, raw_mode = 0;
  logic oc_en = 0, oc_clr = 0;
  logic [7:0] drv_code = '0, exp_code = '0;
  logic [3:0] resp_hi = '0, resp_lo = '0, oc_in = '0;
  logic [3:0] pin_data, pin_en;
  logic [7:0] rec_result;
  logic       rec_valid, err_any;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] m_data = '0, m_en = '0, m_lock = '0;

  always #10 clk = ~clk;

  pinfc_top #(.NCH(NCH)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic bfail(input logic [1:0] c, input logic hi, input logic lo);
    logic [1:0] want;
    if (c == 2'd3) return 1'b0;
    want = (c == 2'd0) ? 2'b01 : (c == 2'd1) ? 2'b10 : 2'b00;
    return {hi, lo} != want;
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic start_step(input logic [7:0] d, input logic [7:0] e);
    step_start = 1; drv_code = d; exp_code = e;
    cyc();
    step_start = 0;
  endtask

  task automatic strobe_model();
    for (int i = 0; i < NCH; i++) begin
      case (drv_code[2*i +: 2])
        2'd0: begin m_data[i] = 0; m_en[i] = 1; end
        2'd1: begin m_data[i] = 1; m_en[i] = 1; end
        2'd2: m_en[i] = 0;
        default: ;
      endcase
    end
    phase_strobe = 1;
    cyc();
    phase_strobe = 0;
  endtask

  // One-cycle window, then close; results readable on return.
  task automatic window1(input logic [3:0] hi, input logic [3:0] lo);
    win = 1; resp_hi = hi; resp_lo = lo;
    cyc();
    win = 0; resp_hi = 4'hF; resp_lo = 4'hF;
    cyc();
  endtask

  function automatic logic [7:0] exp_rec(input logic raw, input logic [7:0] e,
                                         input logic [3:0] failacc, input logic [3:0] hi,
                                         input logic [3:0] lo, input logic [3:0] lk);
    logic [7:0] r = '0;
    for (int i = 0; i < NCH; i++) begin
      if (raw) begin r[2*i+1] = hi[i]; r[2*i] = lo[i]; end
      else r[2*i] = failacc[i] & ~lk[i];
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] f;
    logic [3:0] hi, lo;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 pin_data", pin_data, 0); chk("R1 pin_en", pin_en, 0);
    chk("R1 rec_result", rec_result, 0); chk("R1 rec_valid", rec_valid, 0);
    chk("R1 err_any", err_any, 0);

    // R2/R3: drive sweep through all code combinations
    for (int k = 0; k < 256; k++) begin
      start_step(k[7:0], 8'hFF);
      chk("R2 data held before strobe", pin_data, m_data);
      chk("R2 en held before strobe", pin_en, m_en);
      strobe_model();
      chk("R2/R3 pin_data", pin_data, m_data);
      chk("R2/R3 pin_en", pin_en, m_en);
    end

    // R5/R6/R7/R8: compare sweep
    for (int k = 0; k < 1024; k++) begin
      start_step(8'h00, k[7:0]);
      chk("R8 err cleared by step", err_any, 0);
      for (int i = 0; i < NCH; i++) begin
        logic [1:0] rsp = 2'(k[9:8] + i);
        hi[i] = rsp[1]; lo[i] = rsp[0];
        f[i] = bfail(k[2*i +: 2], hi[i], lo[i]);
      end
      window1(hi, lo);
      chk("R5/R7 compare result", rec_result, exp_rec(0, k[7:0], f, hi, lo, 4'h0));
      chk("R6 rec_valid pulse", rec_valid, 1);
      chk("R8 err_any", err_any, |f);
      cyc();
      chk("R6 rec_valid ends", rec_valid, 0);
    end

    // R7 raw mode
    raw_mode = 1;
    for (int k = 0; k < 64; k++) begin
      start_step(8'h00, 8'h55);
      hi = k[3:0]; lo = 4'(k[5:2] ^ 4'h9);
      window1(hi, lo);
      chk("R7 raw result", rec_result, exp_rec(1, 8'h55, 4'h0, hi, lo, 4'h0));
    end
    raw_mode = 0;

    // R4: responses outside window ignored
    start_step(8'h00, 8'h55);
    resp_hi = 4'h0; resp_lo = 4'hF;
    repeat (3) cyc();
    window1(4'hF, 4'h0);
    chk("R4 outside window ignored", rec_result, 8'h00);
    chk("R4 err_any", err_any, 0);

    // R6: failure in an early window cycle is kept
    start_step(8'h00, 8'h55);
    win = 1; resp_hi = 4'h0; resp_lo = 4'h0; cyc();
    resp_hi = 4'hF; resp_lo = 4'h0; cyc();
    win = 0; cyc();
    chk("R6 accumulate", rec_result, 8'h55);
    chk("R6 accumulate err", err_any, 1);

    // R9/R10/R11: over-current lockout
    start_step(8'h55, 8'h55);
    strobe_model();
    chk("R9 all enabled", pin_en, 4'hF);
    oc_in = 4'b0010; oc_en = 0; cyc();
    chk("R9 oc ignored when disabled", pin_en, 4'hF);
    oc_en = 1; cyc();
    oc_in = 4'b0000;
    chk("R9 locked en", pin_en, 4'b1101);
    chk("R9 data kept", pin_data, 4'hF);
    repeat (4) cyc();
    chk("R10 lock persists", pin_en, 4'b1101);
    start_step(8'hFF, 8'h55);
    window1(4'b1101, 4'b0000);
    chk("R11 locked channel masked", rec_result, 8'h00);
    chk("R11 locked err", err_any, 0);
    oc_clr = 1; cyc(); oc_clr = 0;
    chk("R10/R11 cleared en", pin_en, 4'hF);
    oc_in = 4'b0100; oc_clr = 1; cyc();
    oc_clr = 0; oc_in = 0;
    chk("R10 clear wins", pin_en, 4'hF);
    oc_en = 0;
    start_step(8'hFF, 8'h55);
    window1(4'b1101, 4'b0000);
    chk("R11 unlocked fail counts", rec_result, 8'h04);
    chk("R11 unlocked err", err_any, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule